// File: doc/BRIEF.md
# Sign-Magnitude Sample Output Formatter

This block sits between the quantizer of a receiver's second IF stage and the three data pins that go to the baseband processor. Each rising edge of the sample clock captures three quantizer decisions (sign, upper magnitude bit, lower magnitude bit). The block packs them onto the pins in one of two layouts, chosen by a format bit. The 2-bit layout has sign and one magnitude bit. The 3-bit layout has sign and two magnitude bits. Choosing the 3-bit layout moves the sign from the top pin to the bottom pin.

The same three pins also serve as a small debug bus. A 2-bit bus select is held in a state register, and that state decides what drives the pins. The choices are the normal samples, the serial read-back data, the charge-pump up/down pulses with the filter-calibration flag, or the two synthesizer divider outputs with the reference-clock-selected flag. The sample clock itself is passed out next to the data so the baseband can capture it.

Top module: `sgnmag_fmt`

## Requirements
- R1: While `rst_n` is low, `pin_q` is 3'b000 and the bus state is the sample state. After release, the first edge produces sample-mode output.
- R2: In the sample state with `fmt_two`=1, `pin_q` = {`q_sign`, `q_mag_hi`, 1'b0}. The bottom pin is forced to 0 and `q_mag_lo` has no effect.
- R3: In the sample state with `fmt_two`=0, `pin_q` = {`q_mag_hi`, `q_mag_lo`, `q_sign`}.
- R4: The bus state is loaded from `tbus_sel` on each rising edge. The encodings are 00 sample, 01 serial, 10 pump, 11 divider. The pins change layout at the edge after the one that loads the new state.
- R5: In the serial state (01), `pin_q` = {1'b0, 1'b0, `ser_dout`}. The quantizer inputs and `fmt_two` have no effect.
- R6: In the pump state (10), `pin_q` = {`dbg_cp_up`, `dbg_cp_dn`, `dbg_cal_done`}. The quantizer inputs and `fmt_two` have no effect.
- R7: In the divider state (11), `pin_q` = {`dbg_r_div`, `dbg_m_div`, `dbg_ref_sel`}. The quantizer inputs and `fmt_two` have no effect.
- R8: `pin_q` is registered. It shows the inputs present at the most recent rising edge of `clk` and holds them until the next edge.
- R9: `smp_clk_out` follows `clk` level for level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_two | input | 1 | 1 selects the 2-bit layout, 0 selects the 3-bit layout |
| tbus_sel | input | 2 | Pin function select (00 sample, 01 serial, 10 pump, 11 divider) |
| q_sign | input | 1 | Quantizer sign decision |
| q_mag_hi | input | 1 | Quantizer upper magnitude decision |
| q_mag_lo | input | 1 | Quantizer lower magnitude decision |
| ser_dout | input | 1 | Serial read-back data |
| dbg_cp_up | input | 1 | Charge-pump up pulse |
| dbg_cp_dn | input | 1 | Charge-pump down pulse |
| dbg_cal_done | input | 1 | Filter calibration finished flag |
| dbg_r_div | input | 1 | Reference divider output |
| dbg_m_div | input | 1 | Main divider output |
| dbg_ref_sel | input | 1 | Reference-clock-selected status |
| pin_q | output | 3 | Registered output pins, bit 2 is the top pin |
| smp_clk_out | output | 1 | Sample clock forwarded to the baseband |

## Verification
Random quantizer triples are applied under both format settings. Only the 3-bit layout exposes `q_mag_lo`, and the sign lands on the opposite pin in the two layouts, so swapped or mis-routed bits show up. Random select sequences, including back-to-back changes, tell the state-load edge apart from the output edge. In each debug state, the quantizer inputs and the format bit are toggled against fixed debug inputs. A pin that should stay blind to them would reveal any leak from the sample path. Directed cases cover reset, the forced-zero bottom pin in the 2-bit layout, and the forwarded clock level on both clock phases.

// File: rtl/sgnmag_pkg.sv
package sgnmag_pkg;
    localparam int PIN_W = 3;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        ST_SAMPLE  = 2'b00,
        ST_SERIAL  = 2'b01,
        ST_PUMP    = 2'b10,
        ST_DIVIDER = 2'b11
    } bus_state_e;
endpackage

// File: rtl/sgnmag_bus_fsm.sv
module sgnmag_bus_fsm
    import sgnmag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output bus_state_e       state
);
    bus_state_e nxt;

    // next state: every state moves straight to the one the select names
    always_comb begin
        unique case (sel)
            2'b00:   nxt = ST_SAMPLE;
            2'b01:   nxt = ST_SERIAL;
            2'b10:   nxt = ST_PUMP;
            default: nxt = ST_DIVIDER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SAMPLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/sgnmag_pack.sv
module sgnmag_pack
    import sgnmag_pkg::*;
(
    input  logic             fmt_two,
    input  logic             q_sign,
    input  logic             q_mag_hi,
    input  logic             q_mag_lo,
    output logic [PIN_W-1:0] packed_q
);
    // 2-bit layout puts sign on top and drives the unused bottom pin to 0;
    // 3-bit layout puts the magnitude on top and the sign at the bottom
    always_comb begin
        if (fmt_two) packed_q = {q_sign, q_mag_hi, 1'b0};
        else         packed_q = {q_mag_hi, q_mag_lo, q_sign};
    end
endmodule

// File: rtl/sgnmag_fmt.sv
module sgnmag_fmt
    import sgnmag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_two,
    input  logic [SEL_W-1:0] tbus_sel,
    input  logic             q_sign,
    input  logic             q_mag_hi,
    input  logic             q_mag_lo,
    input  logic             ser_dout,
    input  logic             dbg_cp_up,
    input  logic             dbg_cp_dn,
    input  logic             dbg_cal_done,
    input  logic             dbg_r_div,
    input  logic             dbg_m_div,
    input  logic             dbg_ref_sel,
    output logic [PIN_W-1:0] pin_q,
    output logic             smp_clk_out
);
    bus_state_e       bus_state;
    logic [PIN_W-1:0] sample_word;
    logic [PIN_W-1:0] pin_nxt;

    sgnmag_bus_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (tbus_sel),
        .state (bus_state)
    );

    sgnmag_pack u_pack (
        .fmt_two  (fmt_two),
        .q_sign   (q_sign),
        .q_mag_hi (q_mag_hi),
        .q_mag_lo (q_mag_lo),
        .packed_q (sample_word)
    );

    // output decode per state
    always_comb begin
        unique case (bus_state)
            ST_SAMPLE:  pin_nxt = sample_word;
            ST_SERIAL:  pin_nxt = {2'b00, ser_dout};
            ST_PUMP:    pin_nxt = {dbg_cp_up, dbg_cp_dn, dbg_cal_done};
            ST_DIVIDER: pin_nxt = {dbg_r_div, dbg_m_div, dbg_ref_sel};
            default:    pin_nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_nxt;
    end

    assign smp_clk_out = clk;
endmodule

// File: rtl/sgnmag_fmt_chk.sv
module sgnmag_fmt_chk
    import sgnmag_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             fmt_two,
    input logic [SEL_W-1:0] tbus_sel,
    input logic             q_sign,
    input logic             q_mag_hi,
    input logic             q_mag_lo,
    input logic             ser_dout,
    input logic             dbg_cp_up,
    input logic             dbg_cp_dn,
    input logic             dbg_cal_done,
    input logic             dbg_r_div,
    input logic             dbg_m_div,
    input logic             dbg_ref_sel,
    input logic [PIN_W-1:0] pin_q,
    input bus_state_e       bus_state
);
    a_r2_two_bit_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_SAMPLE && fmt_two) |=>
            pin_q == {$past(q_sign), $past(q_mag_hi), 1'b0});

    a_r3_three_bit_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_SAMPLE && !fmt_two) |=>
            pin_q == {$past(q_mag_hi), $past(q_mag_lo), $past(q_sign)});

    a_r4_state_loads_select: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> bus_state == bus_state_e'($past(tbus_sel)));

    a_r5_serial_route: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_SERIAL) |=> pin_q == {2'b00, $past(ser_dout)});

    a_r6_pump_route: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_PUMP) |=>
            pin_q == {$past(dbg_cp_up), $past(dbg_cp_dn), $past(dbg_cal_done)});

    a_r7_divider_route: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_DIVIDER) |=>
            pin_q == {$past(dbg_r_div), $past(dbg_m_div), $past(dbg_ref_sel)});
endmodule

bind sgnmag_fmt sgnmag_fmt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_two      (fmt_two),
    .tbus_sel     (tbus_sel),
    .q_sign       (q_sign),
    .q_mag_hi     (q_mag_hi),
    .q_mag_lo     (q_mag_lo),
    .ser_dout     (ser_dout),
    .dbg_cp_up    (dbg_cp_up),
    .dbg_cp_dn    (dbg_cp_dn),
    .dbg_cal_done (dbg_cal_done),
    .dbg_r_div    (dbg_r_div),
    .dbg_m_div    (dbg_m_div),
    .dbg_ref_sel  (dbg_ref_sel),
    .pin_q        (pin_q),
    .bus_state    (bus_state)
);

// File: tb/sgnmag_fmt_tb.sv
module sgnmag_fmt_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       fmt_two = 1'b1;
    logic [1:0] tbus_sel = 2'b00;
    logic       q_sign = 0, q_mag_hi = 0, q_mag_lo = 0, ser_dout = 0;
    logic       dbg_cp_up = 0, dbg_cp_dn = 0, dbg_cal_done = 0;
    logic       dbg_r_div = 0, dbg_m_div = 0, dbg_ref_sel = 0;
    logic [2:0] pin_q;
    logic       smp_clk_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] model_sel = 2'b00;

    always #5 clk = ~clk;

    sgnmag_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_two(fmt_two), .tbus_sel(tbus_sel),
        .q_sign(q_sign), .q_mag_hi(q_mag_hi), .q_mag_lo(q_mag_lo),
        .ser_dout(ser_dout), .dbg_cp_up(dbg_cp_up), .dbg_cp_dn(dbg_cp_dn),
        .dbg_cal_done(dbg_cal_done), .dbg_r_div(dbg_r_div), .dbg_m_div(dbg_m_div),
        .dbg_ref_sel(dbg_ref_sel), .pin_q(pin_q), .smp_clk_out(smp_clk_out)
    );

    function automatic logic [2:0] exp_pins(input logic [1:0] st);
        case (st)
            2'b00:   exp_pins = fmt_two ? {q_sign, q_mag_hi, 1'b0}
                                        : {q_mag_hi, q_mag_lo, q_sign};
            2'b01:   exp_pins = {2'b00, ser_dout};
            2'b10:   exp_pins = {dbg_cp_up, dbg_cp_dn, dbg_cal_done};
            default: exp_pins = {dbg_r_div, dbg_m_div, dbg_ref_sel};
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] st);
        case (st)
            2'b00:   req_of = fmt_two ? "R2/R8" : "R3/R8";
            2'b01:   req_of = "R5";
            2'b10:   req_of = "R6";
            default: req_of = "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pin_q=%b expected %b", req, act, exp);
        end
    endtask

    // inputs already driven (at negedge); one edge, then check at next negedge
    task automatic step();
        logic [2:0] e;
        string r;
        e = exp_pins(model_sel);
        r = req_of(model_sel);
        @(negedge clk);
        check(r, pin_q, e);
        model_sel = tbus_sel;
    endtask

    task automatic rand_inputs();
        {q_sign, q_mag_hi, q_mag_lo, ser_dout} = 4'($urandom);
        {dbg_cp_up, dbg_cp_dn, dbg_cal_done} = 3'($urandom);
        {dbg_r_div, dbg_m_div, dbg_ref_sel} = 3'($urandom);
        fmt_two = 1'($urandom);
    endtask

    initial begin
        #100000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #1 rst_n = 1'b0;
        q_sign = 1; q_mag_hi = 1; q_mag_lo = 1; tbus_sel = 2'b11;
        repeat (3) @(negedge clk);
        check("R1 reset", pin_q, 3'b000);
        tbus_sel = 2'b00;
        rst_n = 1'b1;
        model_sel = 2'b00;

        // R1: first edge after release uses sample state
        fmt_two = 1'b0; q_sign = 1; q_mag_hi = 0; q_mag_lo = 1;
        step();

        // R2 directed: bottom pin forced to 0, mag_lo ignored
        fmt_two = 1'b1; q_sign = 1; q_mag_hi = 1; q_mag_lo = 1;
        step();
        check("R2 bottom pin zero", {2'b00, pin_q[0]}, 3'b000);
        // R3 directed: sign at bottom
        fmt_two = 1'b0; q_sign = 1; q_mag_hi = 0; q_mag_lo = 0;
        step();
        check("R3 sign bottom", pin_q, 3'b001);

        // R9: forwarded clock on both phases
        n_chk++; if (smp_clk_out !== 1'b0) begin n_bad++; $display("FAIL R9: smp_clk_out=%b expected 0", smp_clk_out); end
        @(posedge clk); #1;
        n_chk++; if (smp_clk_out !== 1'b1) begin n_bad++; $display("FAIL R9: smp_clk_out=%b expected 1", smp_clk_out); end
        @(negedge clk);
        model_sel = tbus_sel;

        // R4 directed: select to pump, latency of two edges
        dbg_cp_up = 1; dbg_cp_dn = 0; dbg_cal_done = 1;
        fmt_two = 1; q_sign = 0; q_mag_hi = 0;
        tbus_sel = 2'b10;
        step();  // state loads here, pins still sample
        check("R4 still sample", pin_q, 3'b000);
        step();
        check("R4 R6 pump active", pin_q, 3'b101);

        // R5/R6/R7 ignore: toggle quantizer inputs and format per state
        for (int s = 1; s < 4; s++) begin
            tbus_sel = 2'(s);
            step();
            for (int k = 0; k < 8; k++) begin
                {q_sign, q_mag_hi, q_mag_lo} = 3'(k);
                fmt_two = k[0];
                step();
            end
        end

        // constrained random: sample state heavy, debug states mixed in
        for (int i = 0; i < 2000; i++) begin
            rand_inputs();
            tbus_sel = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
            step();
        end
        for (int i = 0; i < 1000; i++) begin
            rand_inputs();
            tbus_sel = 2'($urandom);
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule